// File: doc/BRIEF.md
# Control Register Access Permission Checker

This unit sits between an instruction pipeline and the processor's control register file. Every access carries a 12-bit register address, the current privilege level, a debug-mode flag and the kind of access being requested. The access rights come from fields inside the address itself, not from a table kept for each register. The upper two bits of the address mark whether the register can be written. The next two bits give the lowest privilege level that may touch it. A window of addresses reserved for the debug system is checked on top of those two fields.

A legal access produces a read strobe, a write strobe and read data in the same cycle. An access that breaks any rule is flagged as an illegal instruction. That flag is registered and reaches the pipeline one cycle later, and the trapped access neither reads nor writes anything.

The unit holds a small set of example registers: three scratch registers, a read-only identity register and a control register. The control register is divided into four fields with different rules: a free read/write field, a field of constant bits, a reserved field whose stored value is kept, and a mode field that accepts any written value but only ever reads back a legal one.

Top module: `csr_perm_unit`

## Requirements
- R1: After synchronous reset `illegal_q` is 0, all scratch registers read 0, and the control register at 0x7C0 reads 0x3C5A0000.
- R2: Privilege is encoded 00 user, 01 supervisor, 10 hypervisor, 11 machine, the same as address bits [9:8]. An access is permitted only when the effective level is numerically greater than or equal to address bits [9:8]. Any other access is illegal.
- R3: Address bits [11:10] equal to 11 mark a read-only register. A write intent to such a register is illegal, and a read of it is permitted.
- R4: Only 0x040 (user scratch), 0x140 (supervisor scratch), 0x7C0 (control), 0xF14 (identity) and, when HAS_DEBUG=1, 0x7B2 (debug scratch) exist. An access to any other address is illegal.
- R5: Addresses 0x7B0 to 0x7BF are illegal unless `in_debug` is 1. While `in_debug` is 1 the effective privilege is machine. With HAS_DEBUG=0, every address from 0x7A0 to 0x7BF is illegal.
- R6: Write intent is `wr_req` OR (`setclr_req` AND NOT `src_zero`). A set/clear request with a zero source therefore reads a read-only register without a trap and gives no write strobe.
- R7: `illegal_q` shows, one clock later, whether the access presented in the previous cycle was illegal. An illegal access raises neither `rd_stb` nor `wr_stb` and changes no register.
- R8: Control bits [23:16] always read 0x5A. Writes to them are ignored and do not trap.
- R9: Control mode field bits [3:0] store a written value that has at most one bit set, exactly as written. Any other value is stored as its highest set bit alone. No write to this field traps.
- R10: Control bits [31:24] are a reserved field that keeps its reset value 0x3C across all writes.
- R11: `rdata` is 0 whenever `rd_stb` is 0. The identity register returns the HART_ID parameter (default 7).
- R12: Scratch registers store all 32 written bits, and control bits [15:4] store the written bits. A write takes effect at the clock edge of the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 12 | Register address |
| cur_priv | input | 2 | Current privilege level |
| in_debug | input | 1 | Core is in debug mode |
| rd_req | input | 1 | Access wants the read value |
| wr_req | input | 1 | Plain write request |
| setclr_req | input | 1 | Bit set or bit clear request |
| src_zero | input | 1 | Source operand of the set/clear is zero |
| wdata | input | 32 | Write data (the final value for the register) |
| rd_stb | output | 1 | Legal read of the addressed register |
| wr_stb | output | 1 | Legal write of the addressed register |
| rdata | output | 32 | Read data, 0 when no read strobe |
| illegal_q | output | 1 | Registered illegal-instruction flag |

## Verification
The bench attacks the privilege comparison at its edges. It tries supervisor registers from user level, machine registers from hypervisor level, and higher levels reaching down. A design that used equality instead of greater-or-equal, or that swapped the level encoding, would trap legal accesses or let illegal ones through. The bench also runs set/clear requests with a zero source against the read-only identity register and checks the debug window with and without debug mode. A design that mishandled these would either trap legal reads or hand debug state to machine mode. Finally, it writes illegal values to the mode field, the constant field and the reserved field, then reads them back. It also confirms that a trapped write leaves the target register unchanged, which catches a design that gates only the flag and not the strobe.

// File: rtl/csr_perm_pkg.sv
package csr_perm_pkg;

    typedef enum logic [1:0] {
        PRV_U = 2'b00,
        PRV_S = 2'b01,
        PRV_H = 2'b10,
        PRV_M = 2'b11
    } priv_e;

    // register slots known to the unit
    localparam int NREG     = 5;
    localparam int IDX_USCR = 0;
    localparam int IDX_SSCR = 1;
    localparam int IDX_DSCR = 2;
    localparam int IDX_MCTL = 3;
    localparam int IDX_MID  = 4;
    localparam int NSCR     = 3;   // scratch slots occupy indices 0..NSCR-1

    localparam logic [11:0] A_USCR = 12'h040;
    localparam logic [11:0] A_SSCR = 12'h140;
    localparam logic [11:0] A_DSCR = 12'h7B2;
    localparam logic [11:0] A_MCTL = 12'h7C0;
    localparam logic [11:0] A_MID  = 12'hF14;

    localparam int WARL_W = 4;

    typedef struct packed {
        logic            illegal;
        logic [NREG-1:0] hit;
    } dec_t;

    // legalise the mode field: zero or one bit set passes, otherwise keep the top set bit
    function automatic logic [WARL_W-1:0] warl_fix(input logic [WARL_W-1:0] v);
        logic [WARL_W-1:0] r;
        if ($countones(v) <= 1) begin
            r = v;
        end else begin
            r = '0;
            for (int i = 0; i < WARL_W; i++) begin
                if (v[i]) begin
                    r    = '0;
                    r[i] = 1'b1;
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/csr_perm_dec.sv
module csr_perm_dec
    import csr_perm_pkg::*;
#(
    parameter int HAS_DEBUG = 1
) (
    input  logic [11:0] addr,
    input  logic [1:0]  priv,
    input  logic        dbg,
    input  logic        wr_intent,
    output dec_t        dec
);
    logic [1:0] eff_priv;
    logic       read_only;
    logic       too_low;
    logic       dbg_viol;
    logic       implemented;

    assign eff_priv  = dbg ? PRV_M : priv;
    assign read_only = (addr[11:10] == 2'b11);
    assign too_low   = (eff_priv < addr[9:8]);

    generate
        if (HAS_DEBUG != 0) begin : g_dbg
            assign dbg_viol = (addr[11:4] == 8'h7B) && !dbg;
        end else begin : g_nodbg
            assign dbg_viol = (addr[11:5] == 7'b0111101);
        end
    endgenerate

    always_comb begin
        dec.hit           = '0;
        dec.hit[IDX_USCR] = (addr == A_USCR);
        dec.hit[IDX_SSCR] = (addr == A_SSCR);
        dec.hit[IDX_DSCR] = (HAS_DEBUG != 0) && (addr == A_DSCR);
        dec.hit[IDX_MCTL] = (addr == A_MCTL);
        dec.hit[IDX_MID]  = (addr == A_MID);
    end

    assign implemented = |dec.hit;
    assign dec.illegal = !implemented || too_low || (read_only && wr_intent) || dbg_viol;

endmodule

// File: rtl/csr_perm_regs.sv
module csr_perm_regs
    import csr_perm_pkg::*;
#(
    parameter int          XLEN         = 32,
    parameter int          HART_ID      = 7,
    parameter logic [7:0]  CTL_CONST    = 8'h5A,
    parameter logic [7:0]  CTL_RSV_INIT = 8'h3C
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_stb,
    input  logic            rd_stb,
    input  logic [NREG-1:0] hit,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata
);
    localparam int FREE_LO = WARL_W;
    localparam int FREE_HI = 15;

    logic [XLEN-1:0]        scr_q [NSCR];
    logic [FREE_HI:FREE_LO] ctl_free_q;
    logic [WARL_W-1:0]      ctl_mode_q;
    logic [7:0]             ctl_rsv_q;
    logic [31:0]            ctl_word;

    generate
        for (genvar k = 0; k < NSCR; k++) begin : g_scr
            always_ff @(posedge clk) begin
                if (rst)                  scr_q[k] <= '0;
                else if (wr_stb && hit[k]) scr_q[k] <= wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_free_q <= '0;
            ctl_mode_q <= '0;
            ctl_rsv_q  <= CTL_RSV_INIT;
        end else if (wr_stb && hit[IDX_MCTL]) begin
            ctl_free_q <= wdata[FREE_HI:FREE_LO];
            ctl_mode_q <= warl_fix(wdata[WARL_W-1:0]);
            ctl_rsv_q  <= ctl_rsv_q;   // reserved field preserved
        end
    end

    assign ctl_word = {ctl_rsv_q, CTL_CONST, ctl_free_q, ctl_mode_q};

    always_comb begin
        rdata = '0;
        if (rd_stb) begin
            for (int k = 0; k < NSCR; k++) begin
                if (hit[k]) rdata = scr_q[k];
            end
            if (hit[IDX_MCTL]) rdata = XLEN'(ctl_word);
            if (hit[IDX_MID])  rdata = XLEN'(HART_ID);
        end
    end

endmodule

// File: rtl/csr_perm_unit.sv
module csr_perm_unit
    import csr_perm_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int HART_ID   = 7,
    parameter int HAS_DEBUG = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            acc_valid,
    input  logic [11:0]     acc_addr,
    input  logic [1:0]      cur_priv,
    input  logic            in_debug,
    input  logic            rd_req,
    input  logic            wr_req,
    input  logic            setclr_req,
    input  logic            src_zero,
    input  logic [XLEN-1:0] wdata,
    output logic            rd_stb,
    output logic            wr_stb,
    output logic [XLEN-1:0] rdata,
    output logic            illegal_q
);
    logic wr_intent;
    dec_t dec;

    assign wr_intent = wr_req || (setclr_req && !src_zero);

    csr_perm_dec #(.HAS_DEBUG(HAS_DEBUG)) u_dec (
        .addr      (acc_addr),
        .priv      (cur_priv),
        .dbg       (in_debug),
        .wr_intent (wr_intent),
        .dec       (dec)
    );

    assign rd_stb = acc_valid && rd_req    && !dec.illegal;
    assign wr_stb = acc_valid && wr_intent && !dec.illegal;

    csr_perm_regs #(.XLEN(XLEN), .HART_ID(HART_ID)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (wr_stb),
        .rd_stb (rd_stb),
        .hit    (dec.hit),
        .wdata  (wdata),
        .rdata  (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) illegal_q <= 1'b0;
        else     illegal_q <= acc_valid && dec.illegal;
    end

endmodule

// File: rtl/csr_perm_chk.sv
module csr_perm_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            acc_valid,
    input logic [11:0]     acc_addr,
    input logic [1:0]      cur_priv,
    input logic            in_debug,
    input logic            wr_req,
    input logic            setclr_req,
    input logic            src_zero,
    input logic            rd_stb,
    input logic            wr_stb,
    input logic [XLEN-1:0] rdata,
    input logic            illegal_q
);
    assert_priv_low_R2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !in_debug && (cur_priv < acc_addr[9:8])) |=> illegal_q);

    assert_ro_write_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && (wr_req || (setclr_req && !src_zero)) && (acc_addr[11:10] == 2'b11)) |=> illegal_q);

    assert_dbg_window_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !in_debug && (acc_addr[11:4] == 8'h7B)) |=> illegal_q);

    assert_no_wr_on_trap_R7: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !illegal_q);

    assert_rd_on_ok_R7: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> !illegal_q);

    assert_mode_legal_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && (acc_addr == 12'h7C0)) |-> ($countones(rdata[3:0]) <= 1));

    assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |-> (rdata == '0));
endmodule

bind csr_perm_unit csr_perm_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .cur_priv   (cur_priv),
    .in_debug   (in_debug),
    .wr_req     (wr_req),
    .setclr_req (setclr_req),
    .src_zero   (src_zero),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .rdata      (rdata),
    .illegal_q  (illegal_q)
);

// File: tb/tb_csr_perm_unit.sv
`timescale 1ns/1ps
module tb_csr_perm_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid, in_debug, rd_req, wr_req, setclr_req, src_zero;
    logic [11:0] acc_addr;
    logic [1:0]  cur_priv;
    logic [31:0] wdata, rdata;
    logic        rd_stb, wr_stb, illegal_q;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic        s_rd, s_wr, s_ill;
    logic [31:0] s_rdata;

    always #10 clk = ~clk;

    csr_perm_unit dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .cur_priv(cur_priv), .in_debug(in_debug), .rd_req(rd_req), .wr_req(wr_req),
        .setclr_req(setclr_req), .src_zero(src_zero), .wdata(wdata),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .rdata(rdata), .illegal_q(illegal_q)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] mode_exp(input logic [3:0] v);
        case (v)
            4'h0, 4'h1, 4'h2, 4'h4, 4'h8: return v;
            default: begin
                if (v[3])      return 4'h8;
                else if (v[2]) return 4'h4;
                else           return 4'h2;
            end
        endcase
    endfunction

    function automatic logic [31:0] ctl_exp(input logic [31:0] w);
        return {8'h3C, 8'h5A, w[15:4], mode_exp(w[3:0])};
    endfunction

    // one access: strobes and data sampled mid-cycle, flag sampled after the edge
    task automatic acc(input logic [11:0] a, input logic [1:0] p, input logic dbg,
                       input logic w, input logic sc, input logic sz, input logic r,
                       input logic [31:0] wd);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; cur_priv = p; in_debug = dbg;
        wr_req = w; setclr_req = sc; src_zero = sz; rd_req = r; wdata = wd;
        #2;
        s_rd = rd_stb; s_wr = wr_stb; s_rdata = rdata;
        @(posedge clk);
        #2;
        s_ill = illegal_q;
        acc_valid = 1'b0; wr_req = 1'b0; setclr_req = 1'b0; rd_req = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [1:0] p, input logic dbg);
        acc(a, p, dbg, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0);
    endtask

    task automatic wr(input logic [11:0] a, input logic [1:0] p, input logic dbg, input logic [31:0] d);
        acc(a, p, dbg, 1'b1, 1'b0, 1'b0, 1'b0, d);
    endtask

    task automatic t_reset;
        chk("R1 illegal_q after reset", 32'(illegal_q), 0);
        rd(12'h7C0, 2'b11, 0);
        chk("R1 control reset value", s_rdata, 32'h3C5A0000);
        rd(12'h140, 2'b11, 0);
        chk("R1 scratch reset value", s_rdata, 0);
    endtask

    task automatic t_priv;
        wr(12'h040, 2'b00, 0, 32'hDEADBEEF);
        chk("R2 user writes user reg", 32'(s_ill), 0);
        chk("R12 user write strobe", 32'(s_wr), 1);
        rd(12'h040, 2'b01, 0);
        chk("R2 supervisor reads user reg", s_rdata, 32'hDEADBEEF);
        wr(12'h140, 2'b00, 0, 32'h12345678);
        chk("R2 user to supervisor reg traps", 32'(s_ill), 1);
        chk("R7 trapped write has no strobe", 32'(s_wr), 0);
        rd(12'h140, 2'b01, 0);
        chk("R7 trapped write changed nothing", s_rdata, 0);
        chk("R7 flag clears after legal access", 32'(s_ill), 0);
        wr(12'h140, 2'b10, 0, 32'hA5A5F00F);
        rd(12'h140, 2'b11, 0);
        chk("R12 hypervisor write, machine read", s_rdata, 32'hA5A5F00F);
        rd(12'h7C0, 2'b10, 0);
        chk("R2 hypervisor to machine reg traps", 32'(s_ill), 1);
        chk("R7 trapped read has no strobe", 32'(s_rd), 0);
        chk("R11 rdata zero on trapped read", s_rdata, 0);
    endtask

    task automatic t_readonly;
        rd(12'hF14, 2'b11, 0);
        chk("R11 identity value", s_rdata, 7);
        chk("R3 read-only read permitted", 32'(s_ill), 0);
        wr(12'hF14, 2'b11, 0, 32'h1);
        chk("R3 write to read-only traps", 32'(s_ill), 1);
        rd(12'hF14, 2'b10, 0);
        chk("R2 hypervisor reads machine read-only traps", 32'(s_ill), 1);
    endtask

    task automatic t_unimpl;
        rd(12'h341, 2'b11, 0);
        chk("R4 unimplemented 0x341 traps", 32'(s_ill), 1);
        wr(12'h7C1, 2'b11, 0, 32'h0);
        chk("R4 unimplemented 0x7C1 traps", 32'(s_ill), 1);
    endtask

    task automatic t_debug;
        wr(12'h7B2, 2'b11, 0, 32'hCAFE0001);
        chk("R5 debug window outside debug traps", 32'(s_ill), 1);
        wr(12'h7B2, 2'b00, 1, 32'hCAFE0001);
        chk("R5 debug mode lifts user to machine", 32'(s_ill), 0);
        rd(12'h7B2, 2'b00, 1);
        chk("R5 debug scratch readback", s_rdata, 32'hCAFE0001);
        rd(12'h7A0, 2'b11, 1);
        chk("R4 unimplemented 0x7A0 traps", 32'(s_ill), 1);
    endtask

    task automatic t_setclr;
        acc(12'hF14, 2'b11, 0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0);
        chk("R6 zero-source set/clear on read-only no trap", 32'(s_ill), 0);
        chk("R6 zero-source set/clear no write strobe", 32'(s_wr), 0);
        chk("R6 zero-source set/clear reads value", s_rdata, 7);
        acc(12'hF14, 2'b11, 0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0);
        chk("R6 nonzero set/clear on read-only traps", 32'(s_ill), 1);
        acc(12'h040, 2'b00, 0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0);
        rd(12'h040, 2'b00, 0);
        chk("R6 zero-source set/clear leaves reg", s_rdata, 32'hDEADBEEF);
    endtask

    task automatic t_fields;
        logic [31:0] pats [4] = '{32'hFFFFFFF5, 32'h00000002, 32'h0000ABCF, 32'h12340003};
        foreach (pats[i]) begin
            wr(12'h7C0, 2'b11, 0, pats[i]);
            chk("R9 field write never traps", 32'(s_ill), 0);
            rd(12'h7C0, 2'b11, 0);
            chk("R8 R9 R10 R12 control readback", s_rdata, ctl_exp(pats[i]));
        end
        acc(12'h7C0, 2'b11, 0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
        chk("R11 rdata zero without read", 32'(s_rd) | s_rdata, 0);
    endtask

    initial begin
        rst = 1'b1; acc_valid = 0; acc_addr = '0; cur_priv = '0; in_debug = 0;
        rd_req = 0; wr_req = 0; setclr_req = 0; src_zero = 0; wdata = '0;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        t_reset();
        t_priv();
        t_readonly();
        t_unimpl();
        t_debug();
        t_setclr();
        t_fields();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule